// File: doc/BRIEF.md
# Dithered Second-Order Noise-Shaping Modulus Generator

This block supplies the per-reference-period modulus offset of a fractional-N frequency synthesizer. Each time the feedback divider signals a new reference period, it adds a fixed channel word, a frequency-modulation word and a one-LSB pseudorandom dither bit into a 16-bit two's complement fraction. The fraction lies between -1 and +1. A second-order error-feedback loop then reduces it to a small signed integer. The long-run average of that integer equals the fraction. Its error is pushed towards high frequencies with a (1 - z^-1)^2 shape. The divider adds the integer to its base modulus.

The dither bit comes from an internal 22-bit linear feedback shift register. It breaks up the periodic patterns that a plain error-feedback loop produces for rational inputs. Each period the block also exports its total deviation from the dithered input, y - v, as a signed fraction. A downstream charge-cancellation path can integrate that value. Every register advances only on a cycle where the divider strobe is high, so the block runs at the reference rate inside a faster fabric clock.

Top module: `dsm2_dither_mod`

## Requirements
- R1: The dithered input v is chan_word + mod_word + d, where d is the dither bit when dither_en is 1 and 0 otherwise. All three are taken as 16-bit two's complement values with 15 fraction bits. The sum saturates to the range -32768..32767.
- R2: The dither source is a 22-bit Fibonacci shift register with polynomial x^22 + x^21 + 1. Synchronous reset loads it with 0x1ACE35. The dither bit is state bit 21. On each strobe the state becomes {state[20:0], state[21]^state[20]}. It advances on every strobe, whatever dither_en is.
- R3: Error feedback works in 15-fraction-bit units. First w = v - 2*e1 + e2, where e1 and e2 are the stored errors of the last two strobes. Then y = floor((w + 16384) / 32768), clipped to -2..+2. Finally e = 32768*y - w is clamped to -16384..16384 and stored as the new e1.
- R4: mod_out is a 3-bit two's complement integer and only ever holds -2, -1, 0, +1 or +2.
- R5: qerr_out is a 20-bit two's complement value with 15 fraction bits. It equals 32768*y - v for the same strobe as mod_out.
- R6: The running sum of qerr_out over all results since reset stays within -32768..+32768 (first difference of the shaped error).
- R7: out_valid is high for exactly the one cycle after each cycle with div_strobe high. mod_out and qerr_out change only in that cycle and hold their values otherwise.
- R8: A synchronous active-high reset clears mod_out, qerr_out, out_valid and both stored errors, and restores the dither seed.
- R9: With chan_word = mod_word = 0 and dither_en = 0, every result is mod_out = 0 and qerr_out = 0.
- R10: For a constant input, the sum of mod_out over all results since reset differs from the sum of v/32768 by at most 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| div_strobe | input | 1 | One-cycle pulse per reference period from the feedback divider; clock enable |
| dither_en | input | 1 | Adds the pseudorandom bit at the input LSB when high |
| chan_word | input | 16 | Channel fraction, two's complement, 15 fraction bits |
| mod_word | input | 16 | Modulation fraction, two's complement, 15 fraction bits |
| mod_out | output | 3 | Modulus offset, -2..+2 two's complement |
| qerr_out | output | 20 | Deviation y - v, two's complement, 15 fraction bits |
| out_valid | output | 1 | High the cycle after a strobe when new results are present |

## Verification
A wrong stored error or a wrong dither state shows on the very next strobe. It appears as a mismatch in mod_out, in qerr_out, or in both, against an exact step-by-step model. Because the error feeds back, a single bad sample keeps distorting later results. A scrambled shift register shows up within a few strobes once dither is on, and also in the reset-then-restart sequence. Slower drift, such as a sign error in the feedback weights, breaks the bounded running sum of qerr_out and the mean of mod_out within a few tens of strobes.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;

  localparam int DEF_IN_W      = 16;
  localparam int DEF_LFSR_LEN  = 22;
  localparam int DEF_LFSR_TAP  = 21;
  localparam logic [DEF_LFSR_LEN-1:0] DEF_LFSR_SEED = 22'h1ACE35;
  localparam int DEF_LEVEL_MAX = 2;
  localparam int DEF_OUT_W     = 3;

  typedef enum logic [1:0] {
    LVL_INSIDE = 2'd0,
    LVL_HIGH   = 2'd1,
    LVL_LOW    = 2'd2
  } lvl_clip_e;

endpackage

// File: rtl/dsm2_lfsr.sv
module dsm2_lfsr #(
  parameter int LEN = dsm2_pkg::DEF_LFSR_LEN,
  parameter int TAP = dsm2_pkg::DEF_LFSR_TAP,
  parameter logic [LEN-1:0] SEED = dsm2_pkg::DEF_LFSR_SEED
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic rnd_bit
);

  logic [LEN-1:0] state;
  logic           fb;

  assign fb      = state[LEN-1] ^ state[TAP-1];
  assign rnd_bit = state[LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (adv) begin
      state <= {state[LEN-2:0], fb};
    end
  end

endmodule

// File: rtl/dsm2_input_sum.sv
module dsm2_input_sum #(
  parameter int W = dsm2_pkg::DEF_IN_W
) (
  input  logic [W-1:0] chan,
  input  logic [W-1:0] modw,
  input  logic         rnd_bit,
  input  logic         rnd_en,
  output logic [W-1:0] v
);

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W+1:0] sum;
  logic         ovf_pos;
  logic         ovf_neg;

  always_comb begin
    sum = {{2{chan[W-1]}}, chan}
        + {{2{modw[W-1]}}, modw}
        + {{(W+1){1'b0}}, (rnd_bit & rnd_en)};
    ovf_pos = !sum[W+1] && (sum[W:W-1] != 2'b00);
    ovf_neg =  sum[W+1] && (sum[W:W-1] != 2'b11);
    if (ovf_pos)      v = POS_LIM;
    else if (ovf_neg) v = NEG_LIM;
    else              v = sum[W-1:0];
  end

endmodule

// File: rtl/dsm2_quant.sv
module dsm2_quant #(
  parameter int AW        = 20,
  parameter int FB        = 15,
  parameter int LEVEL_MAX = dsm2_pkg::DEF_LEVEL_MAX,
  parameter int OUT_W     = dsm2_pkg::DEF_OUT_W
) (
  input  logic signed [AW-1:0]    w,
  output logic        [OUT_W-1:0] y_lvl,
  output logic signed [AW-1:0]    y_fix,
  output logic signed [AW-1:0]    e_new
);
  import dsm2_pkg::*;

  localparam logic signed [AW-1:0] HALF  = AW'(2 ** (FB - 1));
  localparam logic signed [AW-1:0] LMAX  = AW'(LEVEL_MAX);
  localparam logic signed [AW-1:0] LMIN  = -LMAX;

  logic signed [AW-1:0] rounded;
  logic signed [AW-1:0] y_full;
  logic signed [AW-1:0] y_sat;
  logic signed [AW-1:0] e_raw;
  lvl_clip_e            clip;

  always_comb begin
    rounded = w + HALF;
    y_full  = rounded >>> FB;
    if (y_full > LMAX)      clip = LVL_HIGH;
    else if (y_full < LMIN) clip = LVL_LOW;
    else                    clip = LVL_INSIDE;
    case (clip)
      LVL_HIGH: y_sat = LMAX;
      LVL_LOW:  y_sat = LMIN;
      default:  y_sat = y_full;
    endcase
  end

  always_comb begin
    y_fix = y_sat <<< FB;
    e_raw = y_fix - w;
    if (e_raw > HALF)       e_new = HALF;
    else if (e_raw < -HALF) e_new = -HALF;
    else                    e_new = e_raw;
  end

  generate
    if (OUT_W >= AW) begin : g_wide
      assign y_lvl = OUT_W'(y_sat);
    end else begin : g_narrow
      assign y_lvl = y_sat[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/dsm2_dither_mod.sv
module dsm2_dither_mod #(
  parameter int IN_W      = dsm2_pkg::DEF_IN_W,
  parameter int LFSR_LEN  = dsm2_pkg::DEF_LFSR_LEN,
  parameter int LFSR_TAP  = dsm2_pkg::DEF_LFSR_TAP,
  parameter logic [LFSR_LEN-1:0] LFSR_SEED = dsm2_pkg::DEF_LFSR_SEED,
  parameter int LEVEL_MAX = dsm2_pkg::DEF_LEVEL_MAX,
  parameter int OUT_W     = dsm2_pkg::DEF_OUT_W,
  localparam int FB       = IN_W - 1,
  localparam int AW       = IN_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_strobe,
  input  logic             dither_en,
  input  logic [IN_W-1:0]  chan_word,
  input  logic [IN_W-1:0]  mod_word,
  output logic [OUT_W-1:0] mod_out,
  output logic [AW-1:0]    qerr_out,
  output logic             out_valid
);

  logic                 rnd_bit;
  logic [IN_W-1:0]      v;
  logic signed [AW-1:0] v_ext;
  logic signed [AW-1:0] e1_q;
  logic signed [AW-1:0] e2_q;
  logic signed [AW-1:0] w;
  logic [OUT_W-1:0]     y_lvl;
  logic signed [AW-1:0] y_fix;
  logic signed [AW-1:0] e_new;
  logic signed [AW-1:0] dev;

  dsm2_lfsr #(
    .LEN (LFSR_LEN),
    .TAP (LFSR_TAP),
    .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .adv    (div_strobe),
    .rnd_bit(rnd_bit)
  );

  dsm2_input_sum #(
    .W(IN_W)
  ) u_sum (
    .chan   (chan_word),
    .modw   (mod_word),
    .rnd_bit(rnd_bit),
    .rnd_en (dither_en),
    .v      (v)
  );

  assign v_ext = {{(AW-IN_W){v[IN_W-1]}}, v};
  assign w     = v_ext - (e1_q <<< 1) + e2_q;

  dsm2_quant #(
    .AW       (AW),
    .FB       (FB),
    .LEVEL_MAX(LEVEL_MAX),
    .OUT_W    (OUT_W)
  ) u_quant (
    .w    (w),
    .y_lvl(y_lvl),
    .y_fix(y_fix),
    .e_new(e_new)
  );

  assign dev = y_fix - v_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      e1_q      <= '0;
      e2_q      <= '0;
      mod_out   <= '0;
      qerr_out  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= div_strobe;
      if (div_strobe) begin
        e1_q     <= e_new;
        e2_q     <= e1_q;
        mod_out  <= y_lvl;
        qerr_out <= dev;
      end
    end
  end

endmodule

// File: rtl/dsm2_dither_mod_chk.sv
module dsm2_dither_mod_chk #(
  parameter int IN_W      = 16,
  parameter int OUT_W     = 3,
  parameter int LEVEL_MAX = 2,
  localparam int AW       = IN_W + 4,
  localparam int SW       = AW + 8
) (
  input logic             clk,
  input logic             rst,
  input logic             div_strobe,
  input logic [OUT_W-1:0] mod_out,
  input logic [AW-1:0]    qerr_out,
  input logic             out_valid
);

  localparam logic signed [SW-1:0] ONE = SW'(2 ** (IN_W - 1));

  logic signed [SW-1:0] run_sum;
  logic signed [SW-1:0] run_next;

  assign run_next = run_sum + (out_valid ? {{(SW-AW){qerr_out[AW-1]}}, qerr_out} : '0);

  always_ff @(posedge clk) begin
    if (rst) run_sum <= '0;
    else     run_sum <= run_next;
  end

  // R4
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    ($signed(mod_out) >= -LEVEL_MAX) && ($signed(mod_out) <= LEVEL_MAX));

  // R6
  shaped_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (run_next <= ONE) && (run_next >= -ONE));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(div_strobe) && !$past(rst)) |-> ($stable(mod_out) && $stable(qerr_out)));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(div_strobe)));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (mod_out == '0 && qerr_out == '0 && !out_valid));

endmodule

bind dsm2_dither_mod dsm2_dither_mod_chk #(
  .IN_W     (IN_W),
  .OUT_W    (OUT_W),
  .LEVEL_MAX(LEVEL_MAX)
) u_dsm2_chk (
  .clk       (clk),
  .rst       (rst),
  .div_strobe(div_strobe),
  .mod_out   (mod_out),
  .qerr_out  (qerr_out),
  .out_valid (out_valid)
);

// File: tb/test_dsm2_dither_mod.sv
module test_dsm2_dither_mod;

  localparam int CLK_PERIOD = 10;
  localparam int FB = 15;
  localparam int ONE = 32768;
  localparam int HALF = 16384;

  typedef struct {
    int    y;
    int    q;
    int    v;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        div_strobe = 1'b0;
  logic        dither_en = 1'b0;
  logic [15:0] chan_word = '0;
  logic [15:0] mod_word = '0;
  logic [2:0]  mod_out;
  logic [19:0] qerr_out;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  item_t sb_q[$];

  int          m_e1, m_e2;
  logic [21:0] m_lfsr;

  int last_y, last_q;
  longint sum_y, sum_v, sum_q;

  dsm2_dither_mod i_dsm2_dither_mod (
    .clk       (clk),
    .rst       (rst),
    .div_strobe(div_strobe),
    .dither_en (dither_en),
    .chan_word (chan_word),
    .mod_word  (mod_word),
    .mod_out   (mod_out),
    .qerr_out  (qerr_out),
    .out_valid (out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_e1 = 0;
    m_e2 = 0;
    m_lfsr = 22'h1ACE35;
  endtask

  task automatic strobe(input int c, input int m, input bit den, input string tag);
    item_t it;
    int v, w, y, e, d;
    d = (den && m_lfsr[21]) ? 1 : 0;
    v = c + m + d;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    w = v - 2 * m_e1 + m_e2;
    y = (w + HALF) >>> FB;
    if (y > 2) y = 2;
    if (y < -2) y = -2;
    e = y * ONE - w;
    if (e > HALF) e = HALF;
    if (e < -HALF) e = -HALF;
    m_e2 = m_e1;
    m_e1 = e;
    m_lfsr = {m_lfsr[20:0], m_lfsr[21] ^ m_lfsr[20]};
    it.y = y; it.q = y * ONE - v; it.v = v; it.tag = tag;
    sb_q.push_back(it);
    chan_word = 16'(c);
    mod_word = 16'(m);
    dither_en = den;
    div_strobe = 1'b1;
    @(negedge clk);
    div_strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    idle(3);
    check(sb_q.size() == 0, "R7 queue drained", sb_q.size(), 0);
  endtask

  task automatic mean_check(input string tag);
    longint diff;
    diff = sum_y * ONE - sum_v;
    check(diff <= ONE && diff >= -ONE, tag, diff, 0);
  endtask

  // monitor: samples a quarter period after each rising edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst) begin
      last_y = 0; last_q = 0; sum_y = 0; sum_v = 0; sum_q = 0;
    end else if (out_valid) begin
      item_t it;
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected out_valid", 1, 0);
      end else begin
        it = sb_q.pop_front();
        check(int'($signed(mod_out)) == it.y, {it.tag, " mod_out"}, int'($signed(mod_out)), it.y);
        check(int'($signed(qerr_out)) == it.q, {it.tag, " R5 qerr_out"}, int'($signed(qerr_out)), it.q);
        check(int'($signed(mod_out)) >= -2 && int'($signed(mod_out)) <= 2, "R4 level", int'($signed(mod_out)), 0);
        sum_y += it.y;
        sum_v += it.v;
        sum_q += int'($signed(qerr_out));
        check(sum_q <= ONE && sum_q >= -ONE, "R6 running qerr sum", sum_q, 0);
      end
      last_y = int'($signed(mod_out));
      last_q = int'($signed(qerr_out));
    end else begin
      check(int'($signed(mod_out)) == last_y && int'($signed(qerr_out)) == last_q,
            "R7 hold without strobe", int'($signed(mod_out)), last_y);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(mod_out == '0, "R8 mod_out after reset", mod_out, 0);
    check(qerr_out == '0, "R8 qerr_out after reset", qerr_out, 0);
    check(out_valid == 1'b0, "R8 out_valid after reset", out_valid, 0);

    // R9: zero input, dither off
    for (int i = 0; i < 40; i++) strobe(0, 0, 1'b0, "R9");
    drain();

    // R3 / R10: DC input with dither
    for (int i = 0; i < 300; i++) strobe(9830, 0, 1'b1, "R3");
    drain();
    mean_check("R10 mean at +0.3");

    // R4: negative DC
    for (int i = 0; i < 200; i++) strobe(-22938, 0, 1'b1, "R4");
    drain();
    mean_check("R10 mean after -0.7");

    // R5: FSK-like modulation word toggling
    for (int i = 0; i < 200; i++) strobe(5000, ((i / 8) % 2 == 0) ? 8000 : -8000, 1'b1, "R5");
    drain();

    // R7: strobes with gaps
    for (int i = 0; i < 60; i++) begin
      strobe(12345, 0, 1'b1, "R7");
      idle(2);
    end
    drain();

    // R2: dither enable toggling, register keeps advancing
    for (int i = 0; i < 100; i++) strobe(777, 0, (i % 2) == 0, "R2");
    drain();

    // R1: saturation at both ends
    for (int i = 0; i < 60; i++) strobe(32767, 32767, 1'b1, "R1 high");
    drain();
    for (int i = 0; i < 60; i++) strobe(-32768, -32768, 1'b1, "R1 low");
    drain();

    // R8: mid-run reset restores seed and clears state
    for (int i = 0; i < 20; i++) strobe(20000, 0, 1'b1, "R3");
    drain();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check(mod_out == '0 && qerr_out == '0 && !out_valid, "R8 mid-run reset", mod_out, 0);
    for (int i = 0; i < 50; i++) strobe(1000, 0, 1'b1, "R2 after reset");
    drain();
    mean_check("R10 mean after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule